// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Pairable Scratch Registers

This block is the arithmetic core of a small nibble-wide controller. It holds one 4-bit accumulator, a carry flag and a bank of sixteen 4-bit scratch registers. The same bank can also be seen as eight 8-bit pairs. Each cycle in which `op_valid` is high, the block executes one operation named by `op_code`. The operation works on the register or pair selected by `op_idx`, and a pair load takes its data from the 8-bit `op_imm`.

The add operation chains through the carry, so wider sums are built one nibble at a time: add the low nibbles, then the upper ones. A subtract uses the carry as an inverted borrow. There are no Boolean operations. The accumulator and carry are always visible at the ports, and the carry doubles as the condition a sequencer tests for a jump on carry. An output operation strobes the accumulator onto a 4-bit port for one cycle.

Reset is asserted asynchronously from `rst_n` and released through a two-stage synchronizer. The block therefore accepts operations from the third rising edge after `rst_n` goes high.

Top module: `nibble_acc_core`

## Requirements
- R1: While reset is held and after it is released, the accumulator, the carry, `port_wr_o` and all sixteen registers are zero.
- R2: Opcode 1 (load) copies register `op_idx` into the accumulator and leaves the carry unchanged.
- R3: Opcode 2 (add) sets {carry, accumulator} to accumulator + register `op_idx` + carry, so the carry is set exactly when the true sum exceeds 15.
- R4: Opcode 3 (subtract) sets {carry, accumulator} to accumulator + (15 - register) + (1 - carry). A carry of 1 afterwards means no borrow occurred.
- R5: Opcode 4 (exchange) swaps the accumulator and register `op_idx` in one cycle and leaves the carry unchanged.
- R6: Opcode 5 (clear) sets both the accumulator and the carry to zero.
- R7: Opcode 6 (pair load) takes p = `op_idx[2:0]`, ignores `op_idx[3]`, writes `op_imm[7:4]` to register 2p and `op_imm[3:0]` to register 2p+1. The accumulator, the carry and all other registers are unchanged.
- R8: Opcode 7 (output) raises `port_wr_o` for exactly one cycle with `port_data_o` equal to the accumulator. The accumulator and the carry are unchanged.
- R9: Opcode 0, opcodes 8 to 15, and any cycle with `op_valid` low change no state and raise no strobe.
- R10: A low-nibble add followed by a high-nibble add, starting from a clear carry, leaves the 8-bit sum in the two result nibbles and bit 8 of the sum in the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation select (encodings in R2 to R9) |
| op_idx | input | 4 | Register index, or pair index in bits 2:0 |
| op_imm | input | 8 | Immediate data for a pair load |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry flag, also the jump-on-carry condition |
| port_wr_o | output | 1 | One-cycle output strobe |
| port_data_o | output | 4 | Data presented with the strobe |

## Verification
Every result is registered and due one clock after the edge that takes the operation: the accumulator, the carry, a register written by an exchange or pair load, and the output strobe. The bench drives each operation on a falling edge and samples on the next falling edge, half a period after the updating edge.

Register contents cannot be read directly. The bench reads a register with a load operation and checks the accumulator one cycle later. Operations that should have no effect are confirmed by reading back the state they could have disturbed before issuing anything else.

Add and subtract are swept over all accumulator, register and carry combinations. Carry chaining is checked over a grid of 8-bit operands.

// File: rtl/nac_pkg.sv
package nac_pkg;

  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] OPC_NOP   = 4'd0;
  localparam logic [CODE_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [CODE_W-1:0] OPC_ADD   = 4'd2;
  localparam logic [CODE_W-1:0] OPC_SUB   = 4'd3;
  localparam logic [CODE_W-1:0] OPC_SWAP  = 4'd4;
  localparam logic [CODE_W-1:0] OPC_CLEAR = 4'd5;
  localparam logic [CODE_W-1:0] OPC_PAIR  = 4'd6;
  localparam logic [CODE_W-1:0] OPC_EMIT  = 4'd7;

  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_REG  = 2'd1,
    ACC_ALU  = 2'd2,
    ACC_ZERO = 2'd3
  } acc_src_e;

  typedef struct packed {
    acc_src_e acc_src;
    logic     carry_ld;
    logic     carry_clr;
    logic     alu_sub;
    logic     reg_we;
    logic     pair_we;
    logic     emit;
  } ctrl_t;

endpackage

// File: rtl/nac_rst_sync.sv
module nac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nac_decode.sv
module nac_decode
  import nac_pkg::*;
(
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '{acc_src: ACC_HOLD, carry_ld: 1'b0, carry_clr: 1'b0,
             alu_sub: 1'b0, reg_we: 1'b0, pair_we: 1'b0, emit: 1'b0};
    if (valid) begin
      unique case (code)
        OPC_LOAD: ctrl.acc_src = ACC_REG;
        OPC_ADD: begin
          ctrl.acc_src  = ACC_ALU;
          ctrl.carry_ld = 1'b1;
        end
        OPC_SUB: begin
          ctrl.acc_src  = ACC_ALU;
          ctrl.carry_ld = 1'b1;
          ctrl.alu_sub  = 1'b1;
        end
        OPC_SWAP: begin
          ctrl.acc_src = ACC_REG;
          ctrl.reg_we  = 1'b1;
        end
        OPC_CLEAR: begin
          ctrl.acc_src   = ACC_ZERO;
          ctrl.carry_clr = 1'b1;
        end
        OPC_PAIR: ctrl.pair_we = 1'b1;
        OPC_EMIT: ctrl.emit    = 1'b1;
        default: ;
      endcase
    end
  end

  // Only one kind of register write can be requested at once.
  always_comb begin
    assert (!(ctrl.reg_we && ctrl.pair_we));
  end

endmodule

// File: rtl/nac_alu.sv
module nac_alu #(
  parameter int unsigned DW = 4
) (
  input  logic          sub,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout
);

  logic [DW-1:0] b_eff;
  logic          c_eff;

  always_comb begin
    b_eff       = sub ? ~b : b;
    c_eff       = sub ? ~cin : cin;
    {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
  end

endmodule

// File: rtl/nac_regfile.sv
module nac_regfile #(
  parameter int unsigned DW   = 4,
  parameter int unsigned NREG = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NREG)-1:0]   raddr,
  output logic [DW-1:0]             rdata,
  input  logic                      we,
  input  logic [$clog2(NREG)-1:0]   waddr,
  input  logic [DW-1:0]             wdata,
  input  logic                      pair_we,
  input  logic [$clog2(NREG)-2:0]   pair_addr,
  input  logic [2*DW-1:0]           pair_data
);

  localparam int unsigned AW  = $clog2(NREG);
  localparam int unsigned PAW = AW - 1;

  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] IDX  = AW'(i);
    localparam logic [PAW-1:0] PIX = PAW'(i / 2);
    logic [DW-1:0] q;
    logic [DW-1:0] d;

    always_comb begin
      d = q;
      if (we && waddr == IDX) begin
        d = wdata;
      end else if (pair_we && pair_addr == PIX) begin
        // even register takes the high nibble
        d = (i % 2 == 0) ? pair_data[2*DW-1:DW] : pair_data[DW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign mem[i] = q;
  end

  assign rdata = mem[raddr];

  // Checker state: last pair written and its data.
  logic [PAW-1:0]  chk_paddr_q;
  logic [2*DW-1:0] chk_pdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_paddr_q <= '0;
      chk_pdata_q <= '0;
    end else if (pair_we) begin
      chk_paddr_q <= pair_addr;
      chk_pdata_q <= pair_data;
    end
  end

  // R7
  pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_we |=> (mem[{chk_paddr_q, 1'b0}] == chk_pdata_q[2*DW-1:DW]) &&
                (mem[{chk_paddr_q, 1'b1}] == chk_pdata_q[DW-1:0]));

endmodule

// File: rtl/nibble_acc_core.sv
module nibble_acc_core
  import nac_pkg::*;
#(
  parameter int unsigned DW   = 4,
  parameter int unsigned NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [CODE_W-1:0]       op_code,
  input  logic [$clog2(NREG)-1:0] op_idx,
  input  logic [2*DW-1:0]         op_imm,
  output logic [DW-1:0]           acc_o,
  output logic                    carry_o,
  output logic                    port_wr_o,
  output logic [DW-1:0]           port_data_o
);

  localparam int unsigned AW  = $clog2(NREG);
  localparam int unsigned PAW = AW - 1;

  logic          rst_sync_n;
  ctrl_t         ctrl;
  logic [DW-1:0] reg_rd;
  logic [DW-1:0] alu_sum;
  logic          alu_cout;

  logic [DW-1:0] acc_q,  acc_d;
  logic          cy_q,   cy_d;
  logic          pwr_q,  pwr_d;
  logic [DW-1:0] pdat_q, pdat_d;
  logic          pdat_en;

  nac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nac_decode u_decode (
    .valid (op_valid),
    .code  (op_code),
    .ctrl  (ctrl)
  );

  nac_regfile #(.DW(DW), .NREG(NREG)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .raddr     (op_idx),
    .rdata     (reg_rd),
    .we        (ctrl.reg_we),
    .waddr     (op_idx),
    .wdata     (acc_q),
    .pair_we   (ctrl.pair_we),
    .pair_addr (op_idx[PAW-1:0]),
    .pair_data (op_imm)
  );

  nac_alu #(.DW(DW)) u_alu (
    .sub  (ctrl.alu_sub),
    .a    (acc_q),
    .b    (reg_rd),
    .cin  (cy_q),
    .sum  (alu_sum),
    .cout (alu_cout)
  );

  // Next state
  always_comb begin
    unique case (ctrl.acc_src)
      ACC_REG:  acc_d = reg_rd;
      ACC_ALU:  acc_d = alu_sum;
      ACC_ZERO: acc_d = '0;
      default:  acc_d = acc_q;
    endcase
    if (ctrl.carry_clr)     cy_d = 1'b0;
    else if (ctrl.carry_ld) cy_d = alu_cout;
    else                    cy_d = cy_q;
    pwr_d   = ctrl.emit;
    pdat_en = ctrl.emit;
    pdat_d  = acc_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
      pwr_q <= pwr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pdat_q <= '0;
    else if (pdat_en) pdat_q <= pdat_d;
  end

  assign acc_o       = acc_q;
  assign carry_o     = cy_q;
  assign port_wr_o   = pwr_q;
  assign port_data_o = pdat_q;

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_CLEAR) |=> (acc_o == '0) && !carry_o);

  // R2
  load_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && (op_code == OPC_LOAD || op_code == OPC_SWAP ||
                  op_code == OPC_PAIR)) |=> $stable(carry_o));

  // R5
  swap_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_SWAP) |=> acc_o == $past(reg_rd));

  // R8
  emit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_EMIT) |=>
      port_wr_o && port_data_o == $past(acc_o) && $stable(acc_o));

  // R9
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(op_valid && op_code == OPC_EMIT) |=> !port_wr_o);

  // R3
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_code == OPC_ADD) |=>
      ({carry_o, acc_o} == ({1'b0, $past(acc_o)} + {1'b0, $past(reg_rd)} +
                            {{DW{1'b0}}, $past(carry_o)})));

endmodule

// File: tb/nibble_acc_core_bench.sv
module nibble_acc_core_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [3:0] op_idx = 4'd0;
  logic [7:0] op_imm = 8'd0;
  logic [3:0] acc_o;
  logic       carry_o;
  logic       port_wr_o;
  logic [3:0] port_data_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nibble_acc_core u_nibble_acc_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .op_idx      (op_idx),
    .op_imm      (op_imm),
    .acc_o       (acc_o),
    .carry_o     (carry_o),
    .port_wr_o   (port_wr_o),
    .port_data_o (port_data_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge, results due.
  task automatic issue(input logic [3:0] c, input logic [3:0] i, input logic [7:0] m);
    op_valid = 1'b1; op_code = c; op_idx = i; op_imm = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle();
    op_valid = 1'b0;
    @(negedge clk);
  endtask

  // acc := a, carry := c, using pair 7 (regs 14, 15)
  task automatic set_acc_carry(input int a, input int c);
    issue(4'd6, 4'd7, {4'hF, 4'(a)});
    issue(4'd5, 4'd0, 8'd0);
    if (c != 0) begin
      issue(4'd1, 4'd14, 8'd0);
      issue(4'd2, 4'd14, 8'd0);   // 15+15 -> carry 1
    end
    issue(4'd1, 4'd15, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc in reset", int'(acc_o), 0);
    check("R1 carry in reset", int'(carry_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 strobe after reset", int'(port_wr_o), 0);
    for (int k = 0; k < 16; k++) begin
      issue(4'd1, 4'(k), 8'd0);
      check("R1 register zero", int'(acc_o), 0);
    end

    // R2 load keeps carry, R6 clear
    for (int c = 0; c < 2; c++) begin
      set_acc_carry(9, c);
      check("R2 load value", int'(acc_o), 9);
      check("R2 load keeps carry", int'(carry_o), c);
      issue(4'd5, 4'd0, 8'd0);
      check("R6 clear acc", int'(acc_o), 0);
      check("R6 clear carry", int'(carry_o), 0);
    end

    // R3/R4 exhaustive
    for (int a = 0; a < 16; a++) begin
      for (int r = 0; r < 16; r++) begin
        for (int c = 0; c < 2; c++) begin
          issue(4'd6, 4'd0, {4'(r), 4'd0});
          set_acc_carry(a, c);
          issue(4'd2, 4'd0, 8'd0);
          check("R3 add sum", int'(acc_o), (a + r + c) % 16);
          check("R3 add carry", int'(carry_o), ((a + r + c) > 15) ? 1 : 0);
          set_acc_carry(a, c);
          issue(4'd3, 4'd0, 8'd0);
          check("R4 sub diff", int'(acc_o), (a + (15 - r) + (1 - c)) % 16);
          check("R4 sub carry", int'(carry_o), (a + (15 - r) + (1 - c)) > 15 ? 1 : 0);
        end
      end
    end

    // R5 exchange
    for (int a = 0; a < 16; a += 3) begin
      for (int c = 0; c < 2; c++) begin
        issue(4'd6, 4'd2, {4'd0, 4'(15 - a)});
        set_acc_carry(a, c);
        issue(4'd4, 4'd5, 8'd0);
        check("R5 swap acc", int'(acc_o), 15 - a);
        check("R5 swap keeps carry", int'(carry_o), c);
        issue(4'd1, 4'd5, 8'd0);
        check("R5 swap reg", int'(acc_o), a);
      end
    end

    // R7 pair load, idx[3] ignored
    for (int p = 0; p < 8; p++) begin
      for (int hi = 0; hi < 2; hi++) begin
        logic [7:0] v;
        v = 8'((p * 37 + hi * 91 + 5) % 256);
        issue(4'd6, 4'd7, 8'h00);
        issue(4'd6, {1'(hi), 3'(p)}, v);
        issue(4'd1, 4'(2 * p), 8'd0);
        check("R7 pair high nibble", int'(acc_o), int'(v[7:4]));
        issue(4'd1, 4'(2 * p + 1), 8'd0);
        check("R7 pair low nibble", int'(acc_o), int'(v[3:0]));
      end
    end
    set_acc_carry(6, 1);
    issue(4'd6, 4'd3, 8'hA5);
    check("R7 pair keeps acc", int'(acc_o), 6);
    check("R7 pair keeps carry", int'(carry_o), 1);

    // R8 output strobe
    for (int a = 0; a < 16; a += 5) begin
      set_acc_carry(a, a % 2);
      issue(4'd7, 4'd0, 8'd0);
      check("R8 strobe high", int'(port_wr_o), 1);
      check("R8 port data", int'(port_data_o), a);
      check("R8 acc kept", int'(acc_o), a);
      check("R8 carry kept", int'(carry_o), a % 2);
      idle();
      check("R8 strobe single cycle", int'(port_wr_o), 0);
    end

    // R9 no effect
    issue(4'd6, 4'd1, 8'h3C);
    set_acc_carry(11, 1);
    op_valid = 1'b0; op_code = 4'd5; @(negedge clk);
    check("R9 invalid clear acc", int'(acc_o), 11);
    check("R9 invalid clear carry", int'(carry_o), 1);
    op_code = 4'd6; op_idx = 4'd1; op_imm = 8'hFF; @(negedge clk);
    op_code = 4'd7; @(negedge clk);
    check("R9 invalid emit strobe", int'(port_wr_o), 0);
    for (int c = 8; c < 16; c++) begin
      issue(4'(c), 4'd2, 8'hFF);
      check("R9 unused code acc", int'(acc_o), 11);
      check("R9 unused code carry", int'(carry_o), 1);
      check("R9 unused code strobe", int'(port_wr_o), 0);
    end
    issue(4'd0, 4'd2, 8'hFF);
    check("R9 nop strobe", int'(port_wr_o), 0);
    issue(4'd1, 4'd2, 8'd0);
    check("R9 pair untouched hi", int'(acc_o), 3);
    issue(4'd1, 4'd3, 8'd0);
    check("R9 pair untouched lo", int'(acc_o), 12);

    // R10 8-bit chained add: pair0=x, pair1=y
    for (int x = 0; x < 256; x += 17) begin
      for (int y = 0; y < 256; y += 23) begin
        issue(4'd6, 4'd0, 8'(x));
        issue(4'd6, 4'd1, 8'(y));
        issue(4'd5, 4'd0, 8'd0);
        issue(4'd1, 4'd1, 8'd0);
        issue(4'd2, 4'd3, 8'd0);
        issue(4'd4, 4'd1, 8'd0);
        issue(4'd1, 4'd0, 8'd0);
        issue(4'd2, 4'd2, 8'd0);
        issue(4'd4, 4'd0, 8'd0);
        check("R10 carry out", int'(carry_o), ((x + y) > 255) ? 1 : 0);
        issue(4'd1, 4'd0, 8'd0);
        check("R10 high nibble", int'(acc_o), ((x + y) / 16) % 16);
        issue(4'd1, 4'd1, 8'd0);
        check("R10 low nibble", int'(acc_o), (x + y) % 16);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule